// File: doc/BRIEF.md
# DMA request sampling controller

This block is the request front end of one DMA channel. It watches an active-low request input, decides in which bus cycle a DMA transfer may begin, and drives an acknowledge output (`dack`), a request-accepted pulse (`drak`) and a one-clock transfer strobe. It contains a small bus model. Bus cycles have a fixed length. The CPU owns every bus cycle that the channel does not claim, so there is always a defined bus-cycle start at which sampling and grants line up.

Three static mode bits set the behaviour:

- Burst or cycle-steal operation.
- Single-address or dual-address acknowledge timing.
- Edge or level request detection.

A transfer length is loaded when the channel is enabled. Each real DMA cycle consumes one unit. When the length runs out, the channel stops taking requests and reports `done`.

Sampling is not continuous. After a request is accepted, the block stops sampling. It starts again at the start of the bus cycle that directly precedes the DMA cycle granted by that request. In burst mode with single-address, level-detected requests, a run starting after a CPU cycle begins with one dummy bus cycle. The dummy cycle is not counted and has no acknowledge.

Top module: `dmarq_ctrl`

## Requirements
- R1: Bus cycles last CYC_CLKS clocks (at least 2). `bus_start` is high on the first clock of every bus cycle, and the first clock after reset starts a bus cycle.
- R2: With `mode_edge`=1, a request is `dreq_n` low in a clock where it was high in the previous clock; a falling edge that arrives while sampling is suspended is lost. With `mode_edge`=0, a request is `dreq_n` low in any clock where sampling is open.
- R3: A request accepted in clock t is granted the first bus cycle whose first clock is at or after t+3 and that also lies after every cycle already granted.
- R4: After a request is accepted, sampling is suspended until the first clock of the bus cycle just before the granted cycle. If that clock is already past, sampling continues on the next clock. After sampling resumes, it runs on every clock until a request is accepted.
- R5: In burst mode, granted DMA cycles may follow each other with no CPU cycle between them.
- R6: In cycle-steal mode, at least one CPU bus cycle separates any two DMA bus cycles.
- R7: With `mode_single`=1, `dack` is high on every clock of a counted DMA cycle. With `mode_single`=0, `dack` is high only on the last clock of that cycle.
- R8: In burst, single-address, level mode, a granted cycle that follows a CPU cycle is preceded by one dummy bus cycle. During the dummy cycle `dack` and `xfer_strobe` stay low, the count does not change, and every pending grant and the resume point move one bus cycle later.
- R9: In edge mode, `drak` is high for exactly the one clock after the clock in which a request was accepted. In level mode, `drak` stays low.
- R10: `xfer_len` is loaded on the first enabled clock. `xfer_strobe` pulses on the first clock of each counted DMA cycle and takes one unit from the count. At zero, `done` is high, no request is accepted, and any grants still pending become CPU cycles.
- R11: Synchronous reset, and `chan_en` low, clear all pending requests, grants and the count. While `chan_en` is low, `dack`, `drak`, `xfer_strobe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 1 | Channel enable; the rising edge loads the length |
| mode_burst | input | 1 | 1 = burst, 0 = cycle steal |
| mode_single | input | 1 | 1 = single address, 0 = dual address |
| mode_edge | input | 1 | 1 = falling-edge detection, 0 = low-level detection |
| xfer_len | input | CNT_W | Number of transfers to perform |
| dreq_n | input | 1 | Transfer request, active low |
| bus_start | output | 1 | First clock of a bus cycle |
| dack | output | 1 | Transfer acknowledge, active high |
| drak | output | 1 | Request-accepted pulse (edge mode) |
| xfer_strobe | output | 1 | One pulse per counted DMA cycle |
| done | output | 1 | Transfer count exhausted |

## Verification
The bench targets the grant latency near bus-cycle boundaries. A design that counts three clocks from the wrong edge would start the first DMA cycle one bus cycle early or late. It also targets the resume point: a block that resumes sampling on the granted cycle instead of the one before it would lose back-to-back burst cycles, and one that never suspends would pile up extra grants. The dummy cycle is checked for its missing acknowledge, its unchanged count, and the one-cycle shift it applies to later grants; an error there either counts the dummy cycle or shifts the real transfer. Edge requests that arrive during suspension, exhaustion of the count while a grant is pending, and mid-run disable are also driven. Each of these shows up as a stray or missing strobe.

// File: rtl/dmarq_pkg.sv
`timescale 1ns/1ps
package dmarq_pkg;

    // kind of the bus cycle currently on the bus
    typedef enum logic [1:0] {
        K_CPU   = 2'd0,
        K_DMA   = 2'd1,
        K_DUMMY = 2'd2
    } bus_kind_e;

    typedef struct packed {
        logic burst;
        logic single;
        logic edge_det;
    } chan_cfg_t;

    // earliest clock distance from a sample to a granted cycle start
    localparam int MIN_LAT = 3;
    // depth of the grant lookahead, in bus cycles
    localparam int SLOTS = 4;
    localparam int SL_W  = $clog2(SLOTS + 1);

    // index (1 = next boundary) of the first boundary meeting MIN_LAT,
    // given the clocks left until the next boundary
    function automatic int first_slot(input int to_bnd, input int cyc);
        if (to_bnd >= MIN_LAT)
            return 1;
        return 1 + (MIN_LAT - to_bnd + cyc - 1) / cyc;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dmarq_bus_timer.sv
`timescale 1ns/1ps
module dmarq_bus_timer #(
    parameter  int CYC_CLKS = 2,
    localparam int PH_W     = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            bnd_now,
    output logic            bnd_next
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ph <= '0;
        else if (ph == PH_LAST)
            ph <= '0;
        else
            ph <= ph + PH_W'(1);
    end

    assign bnd_now  = (ph == '0);
    assign bnd_next = (ph == PH_LAST);

    // R1: the phase never leaves its range, and the last clock wraps to a start
    p_phase_bound_r1: assert property (@(posedge clk) disable iff (rst)
        ph <= PH_LAST);
    p_cycle_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        bnd_next |=> bnd_now);

endmodule

// File: rtl/dmarq_req_detect.sv
`timescale 1ns/1ps
module dmarq_req_detect (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic edge_det,
    input  logic sample_open,
    input  logic dreq_n,
    output logic hit,
    output logic drak_q
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            prev_q <= 1'b1;
        else
            prev_q <= dreq_n;
    end

    always_comb begin
        if (edge_det)
            hit = sample_open && prev_q && !dreq_n;
        else
            hit = sample_open && !dreq_n;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            drak_q <= 1'b0;
        else
            drak_q <= hit && edge_det;
    end

    // R9: the acceptance pulse never lasts two clocks
    p_drak_one_clock_r9: assert property (@(posedge clk) disable iff (rst)
        drak_q |=> !drak_q);

endmodule

// File: rtl/dmarq_xfer_cnt.sv
`timescale 1ns/1ps
module dmarq_xfer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             loaded,
    output logic             cnt_nz,
    output logic             exhausted
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            loaded <= 1'b0;
        end else if (!loaded) begin
            cnt_q  <= load_val;
            loaded <= 1'b1;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_nz    = (cnt_q != '0);
    assign exhausted = loaded && !cnt_nz;

    // R10: an exhausted count stays empty, and no cycle is counted past zero
    p_hold_empty_r10: assert property (@(posedge clk) disable iff (rst || !en)
        (loaded && !cnt_nz) |=> !cnt_nz);
    p_dec_needs_units_r10: assert property (@(posedge clk) disable iff (rst || !en)
        dec |-> cnt_nz);

endmodule

// File: rtl/dmarq_slot_sched.sv
`timescale 1ns/1ps
module dmarq_slot_sched
    import dmarq_pkg::*;
#(
    parameter  int CYC_CLKS = 2,
    localparam int PH_W     = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act,
    input  chan_cfg_t       cfg,
    input  logic [PH_W-1:0] ph,
    input  logic            bnd_now,
    input  logic            bnd_next,
    input  logic            hit,
    input  logic            cnt_nz,
    output bus_kind_e       cur_kind,
    output logic            sample_open,
    output logic            dec
);
    typedef logic [SLOTS-1:0] slot_vec_t;

    slot_vec_t       slots_q;
    logic            susp_q;
    logic [SL_W-1:0] rem_q;

    slot_vec_t       slots_n;
    int              g_sel;
    logic            need_dummy;
    logic            adv;
    logic            susp_pre;
    logic [SL_W-1:0] rem_pre;

    // pick the grant slot for a request seen this clock
    always_comb begin
        int to_bnd;
        int gmin;
        int last;
        int flo;
        to_bnd = CYC_CLKS - int'(ph);
        gmin   = first_slot(to_bnd, CYC_CLKS);
        last   = 0;
        for (int i = 0; i < SLOTS; i++)
            if (slots_q[i])
                last = i + 1;
        if (cfg.burst)
            flo = last + 1;
        else if (last != 0)
            flo = last + 2;
        else
            flo = (cur_kind != K_CPU) ? 2 : 1;
        g_sel = imax(gmin, flo);
    end

    always_comb begin
        slots_n = slots_q;
        if (hit)
            slots_n = slots_q | (slot_vec_t'(1) << (g_sel - 1));
        need_dummy = bnd_next && slots_n[0] && cnt_nz && cfg.burst &&
                     cfg.single && !cfg.edge_det && (cur_kind == K_CPU);
        adv        = bnd_next && !need_dummy;
        susp_pre   = hit ? (g_sel > 1) : susp_q;
        rem_pre    = hit ? SL_W'(g_sel - 1) : rem_q;
        dec        = adv && slots_n[0] && cnt_nz;
    end

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            slots_q  <= '0;
            cur_kind <= K_CPU;
            susp_q   <= 1'b0;
            rem_q    <= '0;
        end else begin
            if (need_dummy) begin
                cur_kind <= K_DUMMY;
                slots_q  <= slots_n;
            end else if (adv) begin
                cur_kind <= (slots_n[0] && cnt_nz) ? K_DMA : K_CPU;
                slots_q  <= slots_n >> 1;
            end else begin
                slots_q  <= slots_n;
            end

            if (adv && susp_pre) begin
                rem_q  <= rem_pre - SL_W'(1);
                susp_q <= (rem_pre != SL_W'(1));
            end else begin
                rem_q  <= rem_pre;
                susp_q <= susp_pre;
            end
        end
    end

    assign sample_open = act && !susp_q && cnt_nz;

    // R3: every grant fits in the lookahead window
    p_slot_range_r3: assert property (@(posedge clk) disable iff (rst || !act)
        hit |-> (g_sel <= SLOTS));
    // R4: sampling resumes only on the first clock of a bus cycle
    p_resume_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(susp_q) && $past(act) && !$past(rst)) |-> bnd_now);
    // R6: in cycle-steal mode a DMA cycle is never followed by another
    p_steal_gap_r6: assert property (@(posedge clk) disable iff (rst || !act)
        (!cfg.burst && cur_kind == K_DMA && bnd_next) |=> (cur_kind != K_DMA));
    // R8: a dummy cycle is always followed by the real transfer
    p_dummy_then_dma_r8: assert property (@(posedge clk) disable iff (rst || !act)
        (cur_kind == K_DUMMY && bnd_next) |=> (cur_kind == K_DMA));

endmodule

// File: rtl/dmarq_ctrl.sv
`timescale 1ns/1ps
module dmarq_ctrl
    import dmarq_pkg::*;
#(
    parameter int CYC_CLKS = 2,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             mode_burst,
    input  logic             mode_single,
    input  logic             mode_edge,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             dreq_n,
    output logic             bus_start,
    output logic             dack,
    output logic             drak,
    output logic             xfer_strobe,
    output logic             done
);
    localparam int PH_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

    chan_cfg_t       cfg;
    logic [PH_W-1:0] ph;
    logic            bnd_now;
    logic            bnd_next;
    logic            hit;
    logic            drak_q;
    logic            sample_open;
    logic            dec;
    logic            loaded;
    logic            cnt_nz;
    logic            exhausted;
    bus_kind_e       cur_kind;

    assign cfg = '{burst: mode_burst, single: mode_single, edge_det: mode_edge};

    dmarq_bus_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .bnd_now  (bnd_now),
        .bnd_next (bnd_next)
    );

    dmarq_req_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .en          (chan_en),
        .edge_det    (cfg.edge_det),
        .sample_open (sample_open),
        .dreq_n      (dreq_n),
        .hit         (hit),
        .drak_q      (drak_q)
    );

    dmarq_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (chan_en),
        .load_val  (xfer_len),
        .dec       (dec),
        .loaded    (loaded),
        .cnt_nz    (cnt_nz),
        .exhausted (exhausted)
    );

    dmarq_slot_sched #(.CYC_CLKS(CYC_CLKS)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .act         (chan_en && loaded),
        .cfg         (cfg),
        .ph          (ph),
        .bnd_now     (bnd_now),
        .bnd_next    (bnd_next),
        .hit         (hit),
        .cnt_nz      (cnt_nz),
        .cur_kind    (cur_kind),
        .sample_open (sample_open),
        .dec         (dec)
    );

    logic in_xfer;
    assign in_xfer     = chan_en && (cur_kind == K_DMA);
    assign bus_start   = bnd_now;
    assign dack        = in_xfer && (cfg.single || ph == PH_LAST);
    assign xfer_strobe = in_xfer && bnd_now;
    assign drak        = chan_en && drak_q;
    assign done        = chan_en && exhausted;

    // R11: while disabled, none of the channel outputs is active
    p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        !chan_en |-> !(dack || drak || xfer_strobe || done));
    // R10: a strobe is only ever seen while the count was still non-zero
    p_strobe_after_dec_r10: assert property (@(posedge clk) disable iff (rst || !chan_en)
        $rose(xfer_strobe) |-> $past(dec));

endmodule

// File: tb/dmarq_ctrl_tb.sv
`timescale 1ns/1ps
module dmarq_ctrl_tb;
    localparam int CYC = 2;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chan_en = 1'b0;
    logic          mode_burst = 1'b0;
    logic          mode_single = 1'b0;
    logic          mode_edge = 1'b0;
    logic [CW-1:0] xfer_len = '0;
    logic          dreq_n = 1'b1;
    logic          bus_start, dack, drak, xfer_strobe, done;

    always #2 clk = ~clk;   // 250 MHz

    dmarq_ctrl #(.CYC_CLKS(CYC), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .mode_burst(mode_burst),
        .mode_single(mode_single), .mode_edge(mode_edge), .xfer_len(xfer_len),
        .dreq_n(dreq_n), .bus_start(bus_start), .dack(dack), .drak(drak),
        .xfer_strobe(xfer_strobe), .done(done)
    );

    int total = 0;
    int bad = 0;
    string scn = "R11";
    int strobes = 0;

    // behavioural reference state
    int t = 0;
    int phase = 0;
    int m_prev = 1;
    int m_enq = 0;
    int m_cnt = 0;
    int m_susp = 0;
    int m_resume = 0;
    int m_cur = 0;      // 0 CPU, 1 DMA, 2 dummy
    int m_drak = 0;
    int grants[$];

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] %s: got %0b expected %0b at t=%0d", req, scn, what, act, exp, t);
        end
    endtask

    task automatic model_reset();
        phase = 0; m_prev = 1; m_enq = 0; m_cnt = 0; m_susp = 0;
        m_resume = 0; m_cur = 0; m_drak = 0; grants.delete();
    endtask

    task automatic compare();
        logic e_dma;
        e_dma = chan_en && (m_cur == 1);
        chk("R1",  bus_start,   logic'(phase == 0), "bus_start");
        chk("R7",  dack,        logic'(e_dma && (mode_single || phase == CYC-1)), "dack");
        chk("R9",  drak,        logic'(chan_en && m_drak != 0), "drak");
        chk("R10", xfer_strobe, logic'(e_dma && phase == 0), "xfer_strobe");
        chk("R10", done,        logic'(chan_en && m_enq != 0 && m_cnt == 0), "done");
        if (xfer_strobe === 1'b1) strobes++;
    endtask

    task automatic model_step();
        int nd;
        nd = 0;
        if (!chan_en) begin
            grants.delete(); m_susp = 0; m_cur = 0; m_prev = 1; m_enq = 0; m_cnt = 0;
        end else if (m_enq == 0) begin
            m_enq = 1; m_cnt = int'(xfer_len); m_prev = int'(dreq_n);
        end else begin
            bit h;
            h = (m_susp == 0) && (m_cnt > 0) &&
                (mode_edge ? (m_prev == 1 && dreq_n == 1'b0) : (dreq_n == 1'b0));
            if (h) begin
                int b0, b;
                nd = mode_edge ? 1 : 0;
                b0 = t + (CYC - phase);
                b = b0;
                while (b < t + 3) b += CYC;
                if (grants.size() > 0) begin
                    int lim;
                    lim = mode_burst ? grants[$] : grants[$] + CYC;
                    while (b <= lim) b += CYC;
                end else if (!mode_burst && m_cur != 0 && b == b0) begin
                    b += CYC;
                end
                grants.push_back(b);
                if (b - CYC > t) begin
                    m_susp = 1; m_resume = b - CYC;
                end
            end
            if (phase == CYC-1) begin
                if (grants.size() > 0 && grants[0] == t + 1) begin
                    if (m_cnt > 0 && mode_burst && mode_single && !mode_edge && m_cur == 0) begin
                        m_cur = 2;
                        foreach (grants[i]) grants[i] += CYC;
                        if (m_susp != 0) m_resume += CYC;
                    end else if (m_cnt > 0) begin
                        m_cur = 1; m_cnt--; void'(grants.pop_front());
                    end else begin
                        m_cur = 0; void'(grants.pop_front());
                    end
                end else begin
                    m_cur = 0;
                end
            end
            if (m_susp != 0 && m_resume == t + 1) m_susp = 0;
            m_prev = int'(dreq_n);
        end
        m_drak = nd;
    endtask

    task automatic tick(input logic r, input logic e, input logic dn);
        @(posedge clk);
        #1;
        rst = r; chan_en = e; dreq_n = dn;
        #1;
        if (r) begin
            model_reset();
        end else begin
            compare();
            model_step();
            phase = (phase + 1) % CYC;
        end
        t++;
    endtask

    int lfsr = 16'hACE1;
    function automatic logic pat(input int kind, input int i, input int n);
        case (kind)
            0: return 1'b0;
            1: return (i % 6 == 3) ? 1'b0 : 1'b1;
            2: return lfsr[0];
            3: return (i < n / 2) ? 1'b0 : 1'b1;
            default: return (i % 5 < 2) ? 1'b0 : 1'b1;
        endcase
    endfunction

    task automatic run_scn(input string tag, input logic b, input logic s, input logic e,
                           input int len, input int kind, input int n, input int off_at);
        scn = tag;
        tick(1'b0, 1'b0, 1'b1);
        mode_burst = b; mode_single = s; mode_edge = e; xfer_len = CW'(len);
        tick(1'b0, 1'b0, 1'b1);
        strobes = 0;
        for (int i = 0; i < n; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0);
            tick(1'b0, (i < off_at || i >= off_at + 3) ? 1'b1 : 1'b0, pat(kind, i, n));
        end
        tick(1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1);
        // R11: reset state, sampled in the first clock after reset
        tick(1'b0, 1'b0, 1'b1);

        run_scn("R3 R4 R6 steal dual level", 1'b0, 1'b0, 1'b0, 5, 0, 80, 1000);
        total++; if (strobes != 5) begin bad++; $display("FAIL R6 strobes got %0d expected 5", strobes); end

        run_scn("R5 burst dual level", 1'b1, 1'b0, 1'b0, 6, 0, 60, 1000);
        total++; if (strobes != 6) begin bad++; $display("FAIL R5 strobes got %0d expected 6", strobes); end

        run_scn("R8 burst single level dummy", 1'b1, 1'b1, 1'b0, 4, 0, 60, 1000);
        total++; if (strobes != 4) begin bad++; $display("FAIL R8 strobes got %0d expected 4", strobes); end

        run_scn("R8 burst single level gaps", 1'b1, 1'b1, 1'b0, 30, 4, 200, 1000);
        run_scn("R2 R9 burst single edge", 1'b1, 1'b1, 1'b1, 12, 1, 150, 1000);
        run_scn("R2 R9 steal single edge random", 1'b0, 1'b1, 1'b1, 40, 2, 400, 1000);
        run_scn("R5 burst dual level random", 1'b1, 1'b0, 1'b0, 25, 2, 300, 1000);
        run_scn("R4 steal dual level release", 1'b0, 1'b0, 1'b0, 50, 3, 120, 1000);

        run_scn("R10 zero length", 1'b1, 1'b1, 1'b0, 0, 0, 30, 1000);
        total++; if (strobes != 0) begin bad++; $display("FAIL R10 strobes got %0d expected 0", strobes); end

        run_scn("R10 exhaust with pending", 1'b1, 1'b0, 1'b0, 3, 0, 60, 1000);
        run_scn("R11 disable mid run", 1'b1, 1'b1, 1'b0, 20, 0, 80, 17);
        run_scn("R11 disable mid run edge", 1'b0, 1'b1, 1'b1, 20, 4, 80, 22);

        // R11: reset in the middle of activity
        scn = "R11 reset";
        mode_burst = 1'b1; mode_single = 1'b0; mode_edge = 1'b0; xfer_len = CW'(9);
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule